// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit up-counters that share one free-running prescaler. Each counter is clocked either from a tap of the prescaler or from an event source. The low timer can count rising edges of an external input. The high timer can count the low timer's compare matches. When a counter reaches its compare value it returns to zero and sends a one-cycle interrupt pulse to the interrupt controller. The two counters can also be joined into a single 16-bit timer. In that case the low half runs through its full range and is cleared only by the high half's match.

A timer flip-flop drives a dedicated output pin. A high-timer match can toggle it, and software can set, clear or invert it with a write. All control state is loaded through a simple register write port.

Top module: `cascade_timer_pair`

## Requirements
- R1: After a synchronous reset, both counters, the prescaler and the flip-flop output are 0, and neither interrupt pulse is asserted.
- R2: The prescaler advances by one per clock only while bit 7 of the run register (write select 0) is 1. While that bit is 0, counters on prescaler taps do not move.
- R3: Low-timer clock source, set by mode register (write select 1) bits 1:0. The value 00 counts rising edges of `ext_tick_in`: the input is synchronised by two flops, a level held high counts once, and the edge is ignored in any other source setting. The values 01, 10 and 11 count once every 128, 512 and 2048 prescaler steps.
- R4: High-timer clock source, set by mode bits 3:2. The value 00 counts low-timer matches, and the values 01, 10 and 11 count once every 128, 2048 and 32768 prescaler steps.
- R5: The compare registers are write select 2 (low) and 3 (high). A count that reaches its compare value becomes 0 on the same clock edge, so the counter cycles through 0 to compare-1. The matching timer's interrupt output (`irq_t0` or `irq_t1`) is high for exactly the one cycle after that edge.
- R6: 16-bit mode is mode bits 7:6 = 01. In this mode a low-timer match neither clears the low timer nor pulses `irq_t0`; the low timer wraps through 255 to 0. A high-timer match clears both timers on the same edge.
- R7: Run bit 0 enables the low timer and run bit 1 the high timer. One cycle after a run bit is written 0, its counter is 0, and it stays 0 while the bit is 0.
- R8: The flip-flop control register is write select 4. Each write applies bits 3:2 at once to the output: 00 inverts it, 01 sets it, 10 clears it, 11 leaves it unchanged. Bit 1 enables inversion of the output on every high-timer match; with bit 1 at 0, matches leave the output alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 run, 1 mode, 2 low compare, 3 high compare, 4 flip-flop control |
| wr_data | input | 8 | Write data |
| ext_tick_in | input | 1 | External count input for the low timer |
| cnt0 | output | CNT_W | Low timer count |
| cnt1 | output | CNT_W | High timer count |
| irq_t0 | output | 1 | Low timer match pulse |
| irq_t1 | output | 1 | High timer match pulse |
| tff_out | output | 1 | Timer flip-flop output |

## Verification
A wrong internal state shows up at the ports in one of three ways. A bad prescaler or wrong tap choice shifts every interrupt pulse by a whole tap period, and the scoreboard sees this at the first expected match, at most 32768 cycles late. A wrong compare or clear path shows in the count outputs within one tick and in a missing or surplus interrupt pulse by the next match. A 16-bit chaining fault shows as a spurious low-timer pulse at the 2nd tick, or as a nonzero low count right after the high match. A flip-flop fault is visible on `tff_out` the cycle after the write or match.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  typedef enum logic [1:0] {
    TFF_INVERT = 2'b00,
    TFF_SET    = 2'b01,
    TFF_CLEAR  = 2'b10,
    TFF_KEEP   = 2'b11
  } tff_cmd_e;

  localparam logic [2:0] SEL_RUN  = 3'd0;
  localparam logic [2:0] SEL_MODE = 3'd1;
  localparam logic [2:0] SEL_CMP0 = 3'd2;
  localparam logic [2:0] SEL_CMP1 = 3'd3;
  localparam logic [2:0] SEL_FFC  = 3'd4;

  localparam logic [1:0] PAIR_16BIT = 2'b01;
endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
  parameter int PRE_W  = 16,
  parameter int N_TAPS = 4,
  parameter logic [N_TAPS*8-1:0] TAP_BITS = {8'd15, 8'd11, 8'd9, 8'd7}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [N_TAPS-1:0] tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)      pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  // a tap bit changes exactly when every lower bit is one and the counter steps
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int B = int'(TAP_BITS[i*8 +: 8]);
    assign tick[i] = run & (&pre_q[B-1:0]);
  end

  logic unused_pre_msb;
  assign unused_pre_msb = pre_q[PRE_W-1];

  p_pre_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pre_q));
  p_pre_step_r2: assert property (@(posedge clk) disable iff (rst)
    run |=> (pre_q == $past(pre_q) + 1'b1));
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             no_self_clear,
  input  logic             force_clear,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             irq_q;

  assign nxt   = cnt_q + 1'b1;
  assign match = run & tick & (nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (force_clear)   cnt_q <= '0;
    else if (tick)          cnt_q <= (match && !no_self_clear) ? '0 : nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= match & ~no_self_clear;
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));
  p_match_wraps_r5: assert property (@(posedge clk) disable iff (rst)
    (match && !no_self_clear) |=> (count == '0) && irq);
  p_hold_on_match_r6: assert property (@(posedge clk) disable iff (rst)
    (match && no_self_clear && !force_clear) |=> (count == $past(cmp)) && !irq);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/ctp_toggle_ff.sv
module ctp_toggle_ff
  import ctp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [1:0] cmd,
  input  logic       hw_toggle,
  output logic       q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else if (cmd_we && cmd != TFF_KEEP) begin
      case (tff_cmd_e'(cmd))
        TFF_INVERT: q_r <= ~q_r;
        TFF_SET:    q_r <= 1'b1;
        TFF_CLEAR:  q_r <= 1'b0;
        default:    q_r <= q_r;
      endcase
    end else if (hw_toggle) q_r <= ~q_r;
  end

  assign q = q_r;

  p_sw_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == TFF_SET) |=> q);
  p_sw_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == TFF_CLEAR) |=> !q);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!hw_toggle && !(cmd_we && cmd != TFF_KEEP)) |=> $stable(q));
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             ext_tick_in,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1,
  output logic             irq_t0,
  output logic             irq_t1,
  output logic             tff_out
);
  localparam int N_TAPS = 4;

  // control state
  logic             pre_run_q, run0_q, run1_q;
  logic [1:0]       src0_q, src1_q, pair_q;
  logic [CNT_W-1:0] cmp0_q, cmp1_q;
  logic             ffc_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_run_q <= 1'b0; run0_q <= 1'b0; run1_q <= 1'b0;
      src0_q <= '0; src1_q <= '0; pair_q <= '0;
      cmp0_q <= '0; cmp1_q <= '0; ffc_en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_RUN: begin
          pre_run_q <= wr_data[7];
          run1_q    <= wr_data[1];
          run0_q    <= wr_data[0];
        end
        SEL_MODE: begin
          pair_q <= wr_data[7:6];
          src1_q <= wr_data[3:2];
          src0_q <= wr_data[1:0];
        end
        SEL_CMP0: cmp0_q   <= wr_data[CNT_W-1:0];
        SEL_CMP1: cmp1_q   <= wr_data[CNT_W-1:0];
        SEL_FFC:  ffc_en_q <= wr_data[1];
        default: ;
      endcase
    end
  end

  logic unused_data;
  assign unused_data = ^{wr_data[5:4]};

  // external input: synchroniser and rising-edge detect
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q, ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_tick_in};
      ext_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end
  assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

  // prescaler taps: index 0..3 = bits 7, 9, 11, 15
  logic [N_TAPS-1:0] tap;

  ctp_prescaler #(
    .PRE_W(PRE_W), .N_TAPS(N_TAPS), .TAP_BITS({8'd15, 8'd11, 8'd9, 8'd7})
  ) u_pre (
    .clk(clk), .rst(rst), .run(pre_run_q), .tick(tap)
  );

  logic tick0, tick1, match0, match1, pair16;
  assign pair16 = (pair_q == PAIR_16BIT);

  always_comb begin
    case (src0_q)
      2'd0:    tick0 = ext_rise;
      2'd1:    tick0 = tap[0];
      2'd2:    tick0 = tap[1];
      default: tick0 = tap[2];
    endcase
    case (src1_q)
      2'd0:    tick1 = match0;
      2'd1:    tick1 = tap[0];
      2'd2:    tick1 = tap[2];
      default: tick1 = tap[3];
    endcase
  end

  ctp_counter #(.CNT_W(CNT_W)) u_lo (
    .clk(clk), .rst(rst), .run(run0_q), .tick(tick0),
    .no_self_clear(pair16), .force_clear(pair16 & match1),
    .cmp(cmp0_q), .count(cnt0), .match(match0), .irq(irq_t0)
  );

  ctp_counter #(.CNT_W(CNT_W)) u_hi (
    .clk(clk), .rst(rst), .run(run1_q), .tick(tick1),
    .no_self_clear(1'b0), .force_clear(1'b0),
    .cmp(cmp1_q), .count(cnt1), .match(match1), .irq(irq_t1)
  );

  ctp_toggle_ff u_tff (
    .clk(clk), .rst(rst),
    .cmd_we(wr_en && wr_sel == SEL_FFC), .cmd(wr_data[3:2]),
    .hw_toggle(ffc_en_q & match1), .q(tff_out)
  );

  p_chain_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (pair16 && match1) |=> (cnt0 == '0) && (cnt1 == '0));
  p_no_low_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (pair16 && match0) |=> !irq_t0);
  p_ext_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (src0_q != 2'd0 && !pre_run_q && !wr_en) |=> $stable(cnt0));
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cnt0 == '0) && (cnt1 == '0) && !irq_t0 && !irq_t1 && !tff_out);
endmodule

// File: tb/cascade_timer_pair_tb.sv
`timescale 1ns/1ps
module cascade_timer_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       ext_tick_in = 1'b0;
  logic [7:0] cnt0, cnt1;
  logic       irq_t0, irq_t1, tff_out;

  cascade_timer_pair u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_tick_in(ext_tick_in), .cnt0(cnt0), .cnt1(cnt1),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .tff_out(tff_out)
  );

  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // scoreboard of expected interrupt pulses: kind (0 low, 1 high) and edge index
  int     sb_kind[$];
  longint sb_when[$];
  string  sb_req[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_irq(input int kind, input longint when, input string req);
    sb_kind.push_back(kind);
    sb_when.push_back(when);
    sb_req.push_back(req);
  endtask

  task automatic pop_irq(input int kind);
    if (sb_kind.size() == 0) begin
      chk(0, "R5", $sformatf("unexpected irq kind %0d at cycle", kind), cyc, -1);
    end else begin
      int k; longint w; string r;
      k = sb_kind.pop_front(); w = sb_when.pop_front(); r = sb_req.pop_front();
      chk(k == kind, r, "irq kind", kind, k);
      chk(w == cyc, r, $sformatf("irq%0d cycle", kind), cyc, w);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (irq_t0) pop_irq(0);
      if (irq_t1) pop_irq(1);
    end
  end

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, output longint w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    w = cyc;
  endtask

  task automatic wait_until(input longint c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(sb_kind.size() == 0, req, "pending expected irqs", sb_kind.size(), 0);
  endtask

  task automatic ext_pulse(input bit expect_hit);
    @(negedge clk);
    ext_tick_in = 1'b1;
    if (expect_hit) expect_irq(0, cyc + 3, "R3");
    repeat (4) @(negedge clk);
    ext_tick_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run hung act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    longint w;
    do_reset();
    // R1 reset state
    chk(cnt0 == 0, "R1", "cnt0", cnt0, 0);
    chk(cnt1 == 0, "R1", "cnt1", cnt1, 0);
    chk(!irq_t0 && !irq_t1, "R1", "irqs", {irq_t1, irq_t0}, 0);
    chk(tff_out == 0, "R1", "tff", tff_out, 0);

    // R2 prescaler halted: timer on tap 7 never moves
    wr(3'd1, 8'h01, w); wr(3'd2, 8'd3, w); wr(3'd0, 8'h01, w);
    wait_until(w + 500);
    chk(cnt0 == 0, "R2", "cnt0 with prescaler off", cnt0, 0);

    // R5 R3 low timer on tap 7, compare 3
    do_reset();
    wr(3'd1, 8'h01, w); wr(3'd2, 8'd3, w); wr(3'd0, 8'h81, w);
    expect_irq(0, w + 384, "R5"); expect_irq(0, w + 768, "R5");
    wait_until(w + 130); chk(cnt0 == 1, "R3", "cnt0 after one tap7 step", cnt0, 1);
    wait_until(w + 300); chk(cnt0 == 2, "R5", "cnt0 mid period", cnt0, 2);
    wait_until(w + 386); chk(cnt0 == 0, "R5", "cnt0 after match", cnt0, 0);
    wait_until(w + 770); drained("R5");

    // R3 tap 9 and tap 11
    do_reset();
    wr(3'd1, 8'h02, w); wr(3'd2, 8'd2, w); wr(3'd0, 8'h81, w);
    expect_irq(0, w + 1024, "R3");
    wait_until(w + 1030); drained("R3");
    do_reset();
    wr(3'd1, 8'h03, w); wr(3'd2, 8'd1, w); wr(3'd0, 8'h81, w);
    expect_irq(0, w + 2048, "R3");
    wait_until(w + 2050); drained("R3");

    // R4 cascade from low-timer matches
    do_reset();
    wr(3'd1, 8'h01, w); wr(3'd2, 8'd2, w); wr(3'd3, 8'd3, w); wr(3'd0, 8'h83, w);
    expect_irq(0, w + 256, "R4"); expect_irq(0, w + 512, "R4");
    expect_irq(0, w + 768, "R4"); expect_irq(1, w + 768, "R4");
    wait_until(w + 600); chk(cnt1 == 2, "R4", "cnt1 after two cascades", cnt1, 2);
    wait_until(w + 770); drained("R4");

    // R4 high timer on taps 7, 11, 15
    do_reset();
    wr(3'd1, 8'h04, w); wr(3'd3, 8'd2, w); wr(3'd0, 8'h82, w);
    expect_irq(1, w + 256, "R4");
    wait_until(w + 260); drained("R4");
    do_reset();
    wr(3'd1, 8'h08, w); wr(3'd3, 8'd1, w); wr(3'd0, 8'h82, w);
    expect_irq(1, w + 2048, "R4");
    wait_until(w + 2050); drained("R4");
    do_reset();
    wr(3'd1, 8'h0C, w); wr(3'd3, 8'd1, w); wr(3'd0, 8'h82, w);
    expect_irq(1, w + 32768, "R4");
    wait_until(w + 32770); drained("R4");

    // R6 16-bit chaining
    do_reset();
    wr(3'd1, 8'h41, w); wr(3'd2, 8'd2, w); wr(3'd3, 8'd2, w); wr(3'd0, 8'h83, w);
    expect_irq(1, w + 128 * 258, "R6");
    wait_until(w + 128 * 3 + 5);
    chk(cnt0 == 3, "R6", "low not cleared on own match", cnt0, 3);
    chk(cnt1 == 1, "R6", "high counted low match", cnt1, 1);
    wait_until(w + 128 * 257 + 5);
    chk(cnt0 == 1, "R6", "low wrapped past 255", cnt0, 1);
    wait_until(w + 128 * 258 + 1);
    chk(cnt0 == 0, "R6", "low cleared by high match", cnt0, 0);
    chk(cnt1 == 0, "R6", "high cleared on match", cnt1, 0);
    drained("R6");

    // R3 external edges
    do_reset();
    wr(3'd1, 8'h00, w); wr(3'd2, 8'd3, w); wr(3'd0, 8'h01, w);
    ext_pulse(0); chk(cnt0 == 1, "R3", "held level counts once", cnt0, 1);
    ext_pulse(0); chk(cnt0 == 2, "R3", "second edge", cnt0, 2);
    ext_pulse(1); chk(cnt0 == 0, "R3", "third edge matches", cnt0, 0);
    drained("R3");
    do_reset();
    wr(3'd1, 8'h01, w); wr(3'd0, 8'h01, w);
    ext_pulse(0); chk(cnt0 == 0, "R3", "edge ignored on tap source", cnt0, 0);

    // R7 run bit clear
    do_reset();
    wr(3'd1, 8'h01, w); wr(3'd2, 8'd9, w); wr(3'd0, 8'h81, w);
    wait_until(w + 300); chk(cnt0 == 2, "R7", "cnt0 running", cnt0, 2);
    wr(3'd0, 8'h80, w);
    @(negedge clk); chk(cnt0 == 0, "R7", "cnt0 after stop", cnt0, 0);
    wait_until(w + 400); chk(cnt0 == 0, "R7", "cnt0 held while stopped", cnt0, 0);

    // R8 software flip-flop commands
    do_reset();
    wr(3'd4, 8'h04, w); chk(tff_out == 1, "R8", "set", tff_out, 1);
    wr(3'd4, 8'h0C, w); chk(tff_out == 1, "R8", "keep", tff_out, 1);
    wr(3'd4, 8'h08, w); chk(tff_out == 0, "R8", "clear", tff_out, 0);
    wr(3'd4, 8'h00, w); chk(tff_out == 1, "R8", "invert", tff_out, 1);
    wr(3'd4, 8'h00, w); chk(tff_out == 0, "R8", "invert back", tff_out, 0);

    // R8 toggle on high match
    wr(3'd4, 8'h0E, w); wr(3'd1, 8'h04, w); wr(3'd3, 8'd1, w); wr(3'd0, 8'h82, w);
    expect_irq(1, w + 128, "R8"); expect_irq(1, w + 256, "R8");
    wait_until(w + 130); chk(tff_out == 1, "R8", "toggle on match", tff_out, 1);
    wait_until(w + 260); chk(tff_out == 0, "R8", "toggle again", tff_out, 0);
    drained("R8");
    do_reset();
    wr(3'd1, 8'h04, w); wr(3'd3, 8'd1, w); wr(3'd0, 8'h82, w);
    expect_irq(1, w + 128, "R8");
    wait_until(w + 130); chk(tff_out == 0, "R8", "no toggle when disabled", tff_out, 0);
    drained("R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule